// File: doc/BRIEF.md
# Write-Masked GPIO Register Port

This block is the register front end of a 32-pin general-purpose I/O bank. It holds the output-level register and the output-enable (direction) register. It also presents the synchronised pin levels and a fixed version word on a simple valid/address/write-data/read-data port.

Each 32-bit logical register is split across two adjacent word addresses. The word at the base offset covers pins 15:0 and the word at base + 4 covers pins 31:16. A write carries its own bit mask: bits 31:16 of the write data enable bits 15:0. Software can therefore set or clear one pin in a single write, with no read-modify-write.

To set pin n, write bit (n mod 16) together with enable bit (n mod 16)+16 to the half chosen by n >= 16. To clear pin n, write the enable bit alone. Reads are combinational on the address. Software rebuilds a full register as (upper word << 16) | lower word.

Top module: `gpio_wm_regport`

## Requirements
- R1: A write changes data bit i (0..15) of the addressed half only when bit i+16 of the write data is 1; the bit then takes the value of write-data bit i. Every other bit keeps its value.
- R2: Byte offset 0x00 holds output levels for pins 15:0 and 0x04 holds pins 31:16. Offset 0x08 holds directions for pins 15:0 and 0x0C holds pins 31:16.
- R3: A read of any half-word register (0x00 to 0x14) returns the 16 data bits in rd_data[15:0], with rd_data[31:16] equal to 0.
- R4: A write whose bits 31:16 are all zero changes no register.
- R5: pin_oe follows the direction register, where 1 means output and 0 means input. pin_out follows the output-level register.
- R6: Offset 0x18 reads the constant 0x01000C2B. Writes to it change nothing.
- R7: Offsets 0x10 (pins 15:0) and 0x14 (pins 31:16) return pin_in after a two-flop synchroniser. A pin_in change set up before clock edge k appears on a read after edge k+1.
- R8: Reset clears the output-level and direction registers, so every pin starts as an input with output level 0.
- R9: The synchronised-input offsets are read-only. An access whose address bits 1:0 are nonzero, or any offset above 0x18, reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe; qualifies writes |
| bus_write | input | 1 | 1 for a write |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data: [31:16] mask, [15:0] data |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Output levels to the pads |
| pin_oe | output | 32 | Output enables to the pads |

## Verification
The assertions assume that every write is a single-cycle strobe with a stable address and data. They also assume that pin_in is sampled cleanly at the clock, because the bench drives it synchronously.

The stimulus drives every input on the falling edge, so setup is always met. It holds bus_valid for exactly one rising edge per write and performs reads with bus_valid low. The synchroniser check also relies on a count of clocks since reset, so that no pre-reset pin history is compared.

// File: rtl/gpio_wm_pkg.sv
package gpio_wm_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned HALF_W = BUS_W / 2;
    localparam logic [BUS_W-1:0] GPIO_VERSION = 32'h0100_0C2B;

    // word index = byte address [4:2]
    typedef enum logic [2:0] {
        W_OUT_LO = 3'd0,
        W_OUT_HI = 3'd1,
        W_DIR_LO = 3'd2,
        W_DIR_HI = 3'd3,
        W_EXT_LO = 3'd4,
        W_EXT_HI = 3'd5,
        W_VER    = 3'd6,
        W_NONE   = 3'd7
    } word_e;
endpackage

// File: rtl/gpio_wm_sync.sv
module gpio_wm_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                chain[k] <= chain[k-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_wm_half_reg.sv
module gpio_wm_half_reg #(
    parameter int unsigned HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2*HW-1:0] wdata,
    output logic [HW-1:0] q
);
    logic [HW-1:0] mask;
    logic [HW-1:0] data;

    assign mask = wdata[2*HW-1:HW];
    assign data = wdata[HW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= (q & ~mask) | (data & mask);
        end
    end
endmodule

// File: rtl/gpio_wm_regport.sv
module gpio_wm_regport
    import gpio_wm_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [BUS_W-1:0]  pin_in,
    output logic [BUS_W-1:0]  pin_out,
    output logic [BUS_W-1:0]  pin_oe
);
    localparam int unsigned NHALF = BUS_W / HALF_W;

    word_e          word;
    logic           wr_stb;
    logic [BUS_W-1:0] ext_sync;

    // decode: misaligned or out-of-range addresses select nothing
    always_comb begin
        word = W_NONE;
        if (bus_addr[1:0] == 2'b00 && bus_addr[ADDR_W-1:2] <= 3'd6) begin
            word = word_e'(bus_addr[4:2]);
        end
    end

    assign wr_stb = bus_valid && bus_write;

    genvar h;
    generate
        for (h = 0; h < NHALF; h++) begin : g_half
            logic sel_out;
            logic sel_dir;
            assign sel_out = wr_stb && (word == word_e'(W_OUT_LO + h));
            assign sel_dir = wr_stb && (word == word_e'(W_DIR_LO + h));

            gpio_wm_half_reg #(.HW(HALF_W)) u_out (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (sel_out),
                .wdata (bus_wdata),
                .q     (pin_out[h*HALF_W +: HALF_W])
            );

            gpio_wm_half_reg #(.HW(HALF_W)) u_dir (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (sel_dir),
                .wdata (bus_wdata),
                .q     (pin_oe[h*HALF_W +: HALF_W])
            );
        end
    endgenerate

    gpio_wm_sync #(.WIDTH(BUS_W), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (ext_sync)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (word)
            W_OUT_LO: bus_rdata[HALF_W-1:0] = pin_out[HALF_W-1:0];
            W_OUT_HI: bus_rdata[HALF_W-1:0] = pin_out[BUS_W-1:HALF_W];
            W_DIR_LO: bus_rdata[HALF_W-1:0] = pin_oe[HALF_W-1:0];
            W_DIR_HI: bus_rdata[HALF_W-1:0] = pin_oe[BUS_W-1:HALF_W];
            W_EXT_LO: bus_rdata[HALF_W-1:0] = ext_sync[HALF_W-1:0];
            W_EXT_HI: bus_rdata[HALF_W-1:0] = ext_sync[BUS_W-1:HALF_W];
            W_VER:    bus_rdata = GPIO_VERSION;
            W_NONE:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_wm_regport_chk.sv
module gpio_wm_regport_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [4:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [31:0] pin_in,
    input logic [31:0] pin_out,
    input logic [31:0] pin_oe
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write) |=> ($stable(pin_out) && $stable(pin_oe))); // R1

    AST_ZERO_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_wdata[31:16] == 16'h0) |=> ($stable(pin_out) && $stable(pin_oe))); // R4

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != 5'h18) |-> (bus_rdata[31:16] == 16'h0)); // R3

    AST_VERSION_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 5'h18) |-> (bus_rdata == 32'h0100_0C2B)); // R6

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && bus_addr == 5'h10) |-> (bus_rdata[15:0] == $past(pin_in[15:0], 2))); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_out == 32'h0 && pin_oe == 32'h0)); // R8

    AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'h0)); // R9
endmodule

bind gpio_wm_regport gpio_wm_regport_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_wm_regport_tb.sv
module gpio_wm_regport_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    gpio_wm_regport u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
        #1;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R8 pin_out after reset", pin_out, 32'h0);
        check("R8 pin_oe after reset", pin_oe, 32'h0);
        rd(5'h08, v);
        check("R8 dir lo read", v, 32'h0);
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        wr(5'h00, 32'h0008_0008);
        check("R1 set pin 3", pin_out, 32'h0000_0008);
        wr(5'h04, 32'h0010_0010);
        check("R2 set pin 20 via upper word", pin_out, 32'h0010_0008);
        rd(5'h04, v);
        check("R3 read upper out word", v, 32'h0000_0010);
        wr(5'h00, 32'h0008_0000);
        check("R1 clear pin 3 only", pin_out, 32'h0010_0000);
        wr(5'h00, 32'h00F0_FFFF);
        check("R1 partial mask", pin_out, 32'h0010_00F0);
    endtask

    task automatic t_dir();
        logic [31:0] v;
        wr(5'h08, 32'h0000_FFFF);
        check("R4 zero mask no change", pin_oe, 32'h0);
        check("R4 zero mask out unchanged", pin_out, 32'h0010_00F0);
        wr(5'h0C, 32'hFFFF_A5A5);
        check("R5 pin_oe from dir upper", pin_oe, 32'hA5A5_0000);
        rd(5'h0C, v);
        check("R2 dir upper read", v, 32'h0000_A5A5);
    endtask

    task automatic t_version();
        logic [31:0] v;
        rd(5'h18, v);
        check("R6 version", v, 32'h0100_0C2B);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, v);
        check("R6 version after write", v, 32'h0100_0C2B);
        check("R6 out untouched", pin_out, 32'h0010_00F0);
    endtask

    task automatic t_ext();
        logic [31:0] v;
        @(negedge clk);
        pin_in = 32'h1234_ABCD;
        bus_addr = 5'h10;
        @(negedge clk); #1;
        check("R7 one edge still old", bus_rdata, 32'h0);
        @(negedge clk); #1;
        check("R7 two edges new low", bus_rdata, 32'h0000_ABCD);
        rd(5'h14, v);
        check("R7 upper ext", v, 32'h0000_1234);
    endtask

    task automatic t_ro_unmapped();
        logic [31:0] v;
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h10, v);
        check("R9 ext read-only", v, 32'h0000_ABCD);
        check("R9 ext write no out change", pin_out, 32'h0010_00F0);
        wr(5'h01, 32'hFFFF_FFFF);
        check("R9 misaligned write ignored", pin_out, 32'h0010_00F0);
        rd(5'h01, v);
        check("R9 misaligned read zero", v, 32'h0);
        rd(5'h1C, v);
        check("R9 unmapped read zero", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_set_clear();
        t_dir();
        t_version();
        t_ext();
        t_ro_unmapped();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1600000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule